// File: doc/BRIEF.md
# Restoring Sequential Divider

This block divides one unsigned integer of parameter width `W` by another over several clock cycles, using the classic subtract, test and restore loop. A one-cycle start strobe, seen while the block is idle, captures both operands. The dividend is placed in a double-width partial-remainder register. The divisor is placed in the upper half of a double-width divisor register whose lower half is cleared. Each step makes a trial subtraction of the divisor register from the remainder register and writes the difference back. If the difference went negative, the divisor is added back. In either case the outcome bit enters the quotient from the right and the divisor register moves one place toward the least significant end.

The loop makes `W+1` steps. Each step takes two cycles: one for the trial subtraction and one for the restore and shift. A single-cycle completion pulse marks the point where quotient and remainder are valid. Both results stay on the outputs until the next accepted start. A zero divisor raises no error. It yields a well-defined pair of results, so the caller never has to test the operands first.

Top module: `restoring_divider`

## Requirements
- R1: While reset is asserted and after its release, `busy` and `done` are 0 and `quotient` and `remainder` are 0.
- R2: A `start` seen at a rising edge while `busy` is 0 captures `dividendIn` and `divisorIn`, and `busy` is 1 from the next cycle on.
- R3: A `start` seen while `busy` is 1 is ignored: the running division finishes on its normal schedule with results computed from the operands captured at its own start.
- R4: For a nonzero divisor, `quotient` equals the integer quotient of dividend by divisor and `remainder` equals the dividend minus quotient times divisor, so `remainder` is less than the divisor.
- R5: For a zero divisor, `quotient` is all ones and `remainder` equals the dividend.
- R6: `done` is high for exactly one cycle, in the cycle that starts 2·W+2 rising edges after the edge that accepted `start`. `busy` falls at that same edge.
- R7: While the block is idle and no `start` is presented, `quotient` and `remainder` keep their values.
- R8: With W=4, dividing 7 by 2 gives quotient 3 and remainder 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; honoured only when idle |
| dividendIn | input | W | Unsigned dividend, sampled with an accepted start |
| divisorIn | input | W | Unsigned divisor, sampled with an accepted start |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| quotient | output | W | Quotient of the last finished division |
| remainder | output | W | Remainder of the last finished division |

## Verification
The bench sweeps every 4-bit operand pair, including all zero-divisor cases. A divider that dropped the extra step, or the extra bit needed to see the sign, would get quotients off by a factor of two or remainders that are not below the divisor. A faulty zero-divisor policy would show up as a quotient other than all ones. Random 16-bit pairs, with directed cases where the divisor is 1, equals the dividend, or exceeds it, catch restore errors that only appear at large widths: a missed add-back leaves the remainder corrupted. A second start injected in the middle of a run, a latency count on every operation, and idle cycles after completion expose a design that restarts, finishes early, or lets its outputs drift.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

  // Strobes from the sequencer to the datapath; at most one is high per cycle.
  typedef struct packed {
    logic load;   // capture operands, clear quotient
    logic trial;  // remainder <= remainder - divisor (sign kept)
    logic fix;    // restore if negative, shift quotient and divisor
  } rdivCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRIAL = 2'd1,
    ST_FIX   = 2'd2
  } rdivState_t;

endpackage

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
  import rdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output rdivCtl_t ctl,
  output logic     busy,
  output logic     done
);

  localparam int STEPS = W + 1;
  localparam int CW    = $clog2(STEPS + 1);

  rdivState_t     state;
  logic [CW-1:0]  stepCnt;
  logic           lastStep;

  assign lastStep = (stepCnt == CW'(STEPS - 1));

  always_comb begin
    ctl       = '0;
    ctl.load  = (state == ST_IDLE) && start;
    ctl.trial = (state == ST_TRIAL);
    ctl.fix   = (state == ST_FIX);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_TRIAL;
            stepCnt <= '0;
          end
        end
        ST_TRIAL: state <= ST_FIX;
        ST_FIX: begin
          if (lastStep) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state   <= ST_TRIAL;
            stepCnt <= stepCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rdiv_datapath.sv
module rdiv_datapath
  import rdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  rdivCtl_t     ctl,
  input  logic [W-1:0] dividendIn,
  input  logic [W-1:0] divisorIn,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);

  localparam int DW = 2 * W;

  logic [DW-1:0] remReg;
  logic [DW-1:0] divReg;
  logic [W-1:0]  quoReg;
  logic          negFlag;
  logic [DW:0]   trialDiff;

  // One extra bit so the sign of the trial difference is explicit.
  assign trialDiff = {1'b0, remReg} - {1'b0, divReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg  <= '0;
      divReg  <= '0;
      quoReg  <= '0;
      negFlag <= 1'b0;
    end else if (ctl.load) begin
      remReg  <= {{W{1'b0}}, dividendIn};
      divReg  <= {divisorIn, {W{1'b0}}};
      quoReg  <= '0;
      negFlag <= 1'b0;
    end else if (ctl.trial) begin
      remReg  <= trialDiff[DW-1:0];
      negFlag <= trialDiff[DW];
    end else if (ctl.fix) begin
      if (negFlag) remReg <= remReg + divReg;
      quoReg <= {quoReg[W-2:0], ~negFlag};
      divReg <= divReg >> 1;
    end
  end

  assign quotient  = quoReg;
  assign remainder = remReg[W-1:0];

endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
  import rdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] dividendIn,
  input  logic [W-1:0] divisorIn,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);

  rdivCtl_t ctl;

  rdiv_ctrl #(.W(W)) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  rdiv_datapath #(.W(W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .dividendIn (dividendIn),
    .divisorIn  (divisorIn),
    .quotient   (quotient),
    .remainder  (remainder)
  );

endmodule

// File: rtl/restoring_divider_chk.sv
module restoring_divider_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic [W-1:0] dividendIn,
  input logic [W-1:0] divisorIn,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder
);

  localparam int LAT = 2 * W + 2;

  logic [W-1:0]   capDvd;
  logic [W-1:0]   capDvs;
  logic [15:0]    latCnt;
  logic [2*W-1:0] recon;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capDvd <= '0;
      capDvs <= '0;
      latCnt <= '0;
    end else if (start && !busy) begin
      capDvd <= dividendIn;
      capDvs <= divisorIn;
      latCnt <= '0;
    end else if (busy) begin
      latCnt <= latCnt + 16'd1;
    end
  end

  assign recon = ({{W{1'b0}}, capDvs} * {{W{1'b0}}, quotient})
               + {{W{1'b0}}, remainder};

  // R1: idle and silent right after reset
  always_comb begin
    if (!rstN) assert_reset_R1: assert (!done) else $error("done high in reset");
  end

  // R2
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R4 (operands captured at accept only, so R3 is covered too)
  assert_result_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && capDvs != '0) |-> (recon == {{W{1'b0}}, capDvd} && remainder < capDvs));

  // R5
  assert_divzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && capDvs == '0) |-> (quotient == '1 && remainder == capDvd));

  // R6 (a restart on a busy start, R3, would also break this count)
  assert_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (latCnt == 16'(LAT)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R7
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));

endmodule

bind restoring_divider restoring_divider_chk #(.W(W)) chk_i (.*);

// File: tb/restoring_divider_tb_top.sv
`timescale 1ns/1ps
module restoring_divider_tb_top;

  localparam int WS = 4;
  localparam int WL = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic          sStart = 1'b0, lStart = 1'b0;
  logic [WS-1:0] sDvd = '0, sDvs = '0, sQuo, sRem;
  logic [WL-1:0] lDvd = '0, lDvs = '0, lQuo, lRem;
  logic          sBusy, sDone, lBusy, lDone;

  restoring_divider #(.W(WS)) dutSmall_i (
    .clk(clk), .rstN(rstN), .start(sStart), .dividendIn(sDvd), .divisorIn(sDvs),
    .busy(sBusy), .done(sDone), .quotient(sQuo), .remainder(sRem));

  restoring_divider #(.W(WL)) dut_i (
    .clk(clk), .rstN(rstN), .start(lStart), .dividendIn(lDvd), .divisorIn(lDvs),
    .busy(lBusy), .done(lDone), .quotient(lQuo), .remainder(lRem));

  function automatic logic [WL-1:0] expQuo(input logic [WL-1:0] a, input logic [WL-1:0] b,
                                           input int w);
    logic [WL-1:0] ones;
    ones = WL'((64'd1 << w) - 1);
    return (b == 0) ? ones : a / b;
  endfunction

  function automatic logic [WL-1:0] expRem(input logic [WL-1:0] a, input logic [WL-1:0] b);
    return (b == 0) ? a : a % b;
  endfunction

  task automatic check(input string req, input logic [WL-1:0] act, input logic [WL-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [WL-1:0] b);
    return (b == 0) ? "R5" : "R4";
  endfunction

  // Small instance: one division, optional stray start mid-run (R3).
  task automatic runSmall(input logic [WS-1:0] a, input logic [WS-1:0] b, input bit stray);
    int n = 0;
    @(negedge clk);
    sDvd = a; sDvs = b; sStart = 1'b1;
    @(negedge clk);
    sStart = 1'b0; n = 1;
    check("R2 busy", WL'(sBusy), 1);
    while (!sDone && n < 100) begin
      if (stray && n == 3) begin sDvd = ~a; sDvs = b + 1'b1; sStart = 1'b1; end
      else sStart = 1'b0;
      @(negedge clk); n++;
    end
    sStart = 1'b0;
    // done is seen in the cycle after the final edge: n-1 edges after accept.
    check("R6 latency", WL'(n - 1), WL'(2 * WS + 2));
    check(reqOf(WL'(b)), WL'(sQuo), expQuo(WL'(a), WL'(b), WS));
    check(reqOf(WL'(b)), WL'(sRem), expRem(WL'(a), WL'(b)));
    @(negedge clk);
    check("R6 pulse", WL'(sDone), 0);
  endtask

  task automatic runWide(input logic [WL-1:0] a, input logic [WL-1:0] b, input bit stray,
                         input bit idleChk);
    int n = 0;
    @(negedge clk);
    lDvd = a; lDvs = b; lStart = 1'b1;
    @(negedge clk);
    lStart = 1'b0; n = 1;
    while (!lDone && n < 200) begin
      if (stray && n == 7) begin lDvd = a ^ 16'h5a5a; lDvs = b ^ 16'h0101; lStart = 1'b1; end
      else lStart = 1'b0;
      @(negedge clk); n++;
    end
    lStart = 1'b0;
    check(stray ? "R3 latency" : "R6 latency", WL'(n - 1), WL'(2 * WL + 2));
    check(stray ? "R3 quotient" : reqOf(b), lQuo, expQuo(a, b, WL));
    check(stray ? "R3 remainder" : reqOf(b), lRem, expRem(a, b));
    if (idleChk) begin
      lDvd = ~a; lDvs = 16'd3;
      repeat (4) @(negedge clk);
      check("R7 quotient", lQuo, expQuo(a, b, WL));
      check("R7 remainder", lRem, expRem(a, b));
      check("R7 busy", WL'(lBusy), 0);
    end
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog actual=%0d expected=<200000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [WL-1:0] a, b;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 busy", WL'(lBusy), 0);
    check("R1 done", WL'(lDone), 0);
    check("R1 quotient", lQuo, 0);
    check("R1 remainder", lRem, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 small quotient", WL'(sQuo), 0);
    check("R1 small busy", WL'(sBusy), 0);

    // R8 directed example
    runSmall(4'd7, 4'd2, 1'b0);
    check("R8 quotient", WL'(sQuo), 3);
    check("R8 remainder", WL'(sRem), 1);

    // R4/R5: every 4-bit pair
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        runSmall(WS'(i), WS'(j), 1'b0);

    // R3 on the small instance
    runSmall(4'd13, 4'd4, 1'b1);

    // Directed wide corners
    runWide(16'hffff, 16'h0001, 1'b0, 1'b0);
    runWide(16'hffff, 16'hffff, 1'b0, 1'b0);
    runWide(16'h1234, 16'hffff, 1'b0, 1'b0);
    runWide(16'h0000, 16'h0007, 1'b0, 1'b0);
    runWide(16'hbeef, 16'h0000, 1'b0, 1'b1);
    runWide(16'h8000, 16'h8001, 1'b0, 1'b0);
    runWide(16'hc350, 16'h00fa, 1'b1, 1'b1);

    // Random wide pairs
    for (int k = 0; k < 300; k++) begin
      a = WL'($urandom);
      b = (k % 3 == 0) ? WL'($urandom) >> ($urandom % 16) : WL'($urandom);
      if (k % 50 == 0) b = '0;
      runWide(a, b, (k % 40 == 5), (k % 25 == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule